// File: doc/BRIEF.md
# Disk Controller Command-Phase Handshake

This block paces the byte-wide host side of a disk controller. It has one data port and an 8-bit status word. The host writes an opcode and then its parameter bytes. For data-transfer commands the block waits out an execution phase. It then lets the host read back the result bytes. The status word tells the host when it may move a byte and in which direction.

A fixed table, built from a function when the design is elaborated, looks at the low five bits of the opcode and gives three things: the parameter count, the result count, and whether an execution phase follows. The table holds these entries:

| Code | Parameters | Results | Execution phase |
|------|-----------|---------|-----------------|
| 0x03 | 2 | 0 | no |
| 0x04 | 1 | 1 | no |
| 0x05 | 8 | 7 | yes |
| 0x06 | 8 | 7 | yes |
| 0x07 | 1 | 0 | no |
| 0x08 | 0 | 2 | no |
| 0x0F | 2 | 0 | no |
| any other code | 0 | 1 | no |

Commands with no result bytes, such as seek and recalibrate, finish as soon as their last byte arrives. Each drive has a seek-active input, and the block copies these into the per-drive busy bits. The datapath hands bytes to a downstream sequencer and takes result data from it. It does this through strobes and byte indices.

Top module: `fdc_cmd_handshake`

## Requirements
- R1: After reset the status word is 0x80: request set, direction 0 (host writes), not busy. The block is idle and waits for an opcode, and `proto_err` is 0.
- R2: The status bits are laid out as follows: bit 7 is request, bit 6 is direction (1 means the host reads), bit 4 is command busy, and bits 1:0 are the drive-busy flags. Bit 5 (non-DMA) and bits 3:2 always read 0.
- R3: The parameter count, result count and execution-phase flag of a command come from the opcode table above. The table is indexed by the low five opcode bits, and the top three opcode bits are ignored.
- R4: Command busy rises in the first status word after the opcode is accepted. It falls in the status word after the last result byte is read. If a command has no result bytes, it falls in the status word after its last command byte.
- R5: Direction is 0 while the block waits for opcode or parameter bytes. It is 1 throughout the result phase.
- R6: After every accepted data-port access, request reads 0 for exactly one status word. It then reasserts, unless the block has entered its execution phase.
- R7: For codes 0x05 and 0x06, request stays 0 after the last parameter until `exec_done` is pulsed. The next status word then shows the result phase (0xD0 with drives idle).
- R8: Drive-busy bit i equals `seek_active[i]` from the previous clock.
- R9: A data-port write or read while request is 0, or in the direction opposite to the direction bit, is ignored: no strobe is issued and the phase does not change. Such an access sets `proto_err`, which stays 1 until reset.
- R10: An accepted write gives a one-clock `take_valid` pulse on the next clock, with the byte on `take_data`. `take_idx` is 0 for the opcode and counts up from 1 for the parameters. An accepted read gives a one-clock `res_pop` pulse, with `res_idx` counting the result bytes from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dp_wr | input | 1 | Host write strobe for the data port |
| dp_rd | input | 1 | Host read strobe for the data port |
| dp_wdata | input | 8 | Byte written by the host |
| seek_active | input | NUM_DRV | Per-drive seek in progress |
| exec_done | input | 1 | End of the execution phase |
| status | output | 8 | Main status word |
| take_valid | output | 1 | Command byte accepted (pulse) |
| take_data | output | 8 | Accepted command byte |
| take_idx | output | 4 | Position of that byte in the command |
| res_pop | output | 1 | Result byte consumed by the host (pulse) |
| res_idx | output | 4 | Position of that result byte |
| exec_phase | output | 1 | Block is in its execution phase |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The following are checked on every cycle, from port signals alone: the reserved and non-DMA bits stay zero, request drops after each accepted byte, a result-phase direction always comes with command busy, the drive flags track their inputs, and the error flag is set and then held. The per-opcode byte counts, the exact cycle in which busy falls for commands with and without results, and the rejection of out-of-turn accesses can only be shown by scenarios. To cover these, the bench sweeps every table code through complete commands.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;
  localparam int CNT_W = 4;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] n_par;
    logic [CNT_W-1:0] n_res;
    logic             run;
  } op_info_t;

  function automatic op_info_t op_lookup(input logic [CODE_W-1:0] code);
    op_info_t r;
    case (code)
      5'h03:   r = '{n_par: 4'd2, n_res: 4'd0, run: 1'b0};
      5'h04:   r = '{n_par: 4'd1, n_res: 4'd1, run: 1'b0};
      5'h05:   r = '{n_par: 4'd8, n_res: 4'd7, run: 1'b1};
      5'h06:   r = '{n_par: 4'd8, n_res: 4'd7, run: 1'b1};
      5'h07:   r = '{n_par: 4'd1, n_res: 4'd0, run: 1'b0};
      5'h08:   r = '{n_par: 4'd0, n_res: 4'd2, run: 1'b0};
      5'h0F:   r = '{n_par: 4'd2, n_res: 4'd0, run: 1'b0};
      default: r = '{n_par: 4'd0, n_res: 4'd1, run: 1'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hs_op_table.sv
module hs_op_table
  import fdc_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output op_info_t      info
);
  always_comb info = op_lookup(opcode[CODE_W-1:0]);
endmodule

// File: rtl/hs_drive_flags.sv
module hs_drive_flags #(
  parameter int NUM_DRV = 2,
  parameter int FIELD_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DRV-1:0] seek_active,
  output logic [FIELD_W-1:0] drv_busy
);
  for (genvar i = 0; i < FIELD_W; i++) begin : g_drv
    if (i < NUM_DRV) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) drv_busy[i] <= 1'b0;
        else     drv_busy[i] <= seek_active[i];
      end
    end else begin : g_tie
      assign drv_busy[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
  import fdc_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  logic             rd_ok,
  input  logic             exec_done,
  input  logic [DW-1:0]    wdata,
  input  op_info_t         info,
  output logic             rqm,
  output logic             dio,
  output logic             busy,
  output logic             exec_phase,
  output logic             take_valid,
  output logic [DW-1:0]    take_data,
  output logic [CNT_W-1:0] take_idx,
  output logic             res_pop,
  output logic [CNT_W-1:0] res_idx
);
  phase_e           ph, ph_n;
  logic [CNT_W-1:0] left, left_n;
  logic [CNT_W-1:0] nres, nres_n;
  logic             run, run_n;
  logic [CNT_W-1:0] idx;
  logic             gap_n;

  always_comb begin
    ph_n   = ph;
    left_n = left;
    nres_n = nres;
    run_n  = run;
    gap_n  = wr_ok | rd_ok;
    case (ph)
      PH_IDLE: if (wr_ok) begin
        nres_n = info.n_res;
        run_n  = info.run;
        if (info.n_par != '0) begin
          ph_n = PH_CMD;  left_n = info.n_par;
        end else if (info.run) begin
          ph_n = PH_EXEC;
        end else if (info.n_res != '0) begin
          ph_n = PH_RES;  left_n = info.n_res;
        end
      end
      PH_CMD: if (wr_ok) begin
        if (left == CNT_W'(1)) begin
          if (run) ph_n = PH_EXEC;
          else if (nres != '0) begin ph_n = PH_RES; left_n = nres; end
          else ph_n = PH_IDLE;
        end else begin
          left_n = left - CNT_W'(1);
        end
      end
      PH_EXEC: if (exec_done) begin
        if (nres != '0) begin ph_n = PH_RES; left_n = nres; end
        else ph_n = PH_IDLE;
      end
      PH_RES: if (rd_ok) begin
        if (left == CNT_W'(1)) ph_n = PH_IDLE;
        else left_n = left - CNT_W'(1);
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; left <= '0; nres <= '0; run <= 1'b0; idx <= '0;
      rqm <= 1'b1; dio <= 1'b0; busy <= 1'b0; exec_phase <= 1'b0;
      take_valid <= 1'b0; take_data <= '0; take_idx <= '0;
      res_pop <= 1'b0; res_idx <= '0;
    end else begin
      ph   <= ph_n;
      left <= left_n;
      nres <= nres_n;
      run  <= run_n;
      rqm  <= ~gap_n & (ph_n != PH_EXEC);
      dio  <= (ph_n == PH_RES);
      busy <= (ph_n != PH_IDLE);
      exec_phase <= (ph_n == PH_EXEC);
      take_valid <= wr_ok;
      res_pop    <= rd_ok;
      if (wr_ok) begin
        take_data <= wdata;
        take_idx  <= (ph == PH_IDLE) ? '0 : idx;
        idx       <= (ph == PH_IDLE) ? CNT_W'(1) : idx + CNT_W'(1);
      end
      if (rd_ok) res_idx <= nres - left;
    end
  end
endmodule

// File: rtl/fdc_cmd_handshake.sv
module fdc_cmd_handshake
  import fdc_hs_pkg::*;
#(
  parameter int NUM_DRV = 2,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dp_wr,
  input  logic               dp_rd,
  input  logic [DW-1:0]      dp_wdata,
  input  logic [NUM_DRV-1:0] seek_active,
  input  logic               exec_done,
  output logic [7:0]         status,
  output logic               take_valid,
  output logic [DW-1:0]      take_data,
  output logic [CNT_W-1:0]   take_idx,
  output logic               res_pop,
  output logic [CNT_W-1:0]   res_idx,
  output logic               exec_phase,
  output logic               proto_err
);
  localparam int DRV_FIELD = 2;

  logic                 rqm, dio, busy;
  logic [DRV_FIELD-1:0] drv_busy;
  logic                 wr_ok, rd_ok, bad;
  op_info_t             info;

  assign wr_ok = dp_wr & rqm & ~dio;
  assign rd_ok = dp_rd & rqm & dio;
  assign bad   = (dp_wr & ~wr_ok) | (dp_rd & ~rd_ok);

  hs_op_table #(.DW(DW)) u_tab (.opcode(dp_wdata), .info(info));

  hs_drive_flags #(.NUM_DRV(NUM_DRV), .FIELD_W(DRV_FIELD)) u_drv (
    .clk(clk), .rst(rst), .seek_active(seek_active), .drv_busy(drv_busy)
  );

  hs_phase_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .exec_done(exec_done), .wdata(dp_wdata), .info(info),
    .rqm(rqm), .dio(dio), .busy(busy), .exec_phase(exec_phase),
    .take_valid(take_valid), .take_data(take_data), .take_idx(take_idx),
    .res_pop(res_pop), .res_idx(res_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else if (bad) proto_err <= 1'b1;
  end

  assign status = {rqm, dio, 1'b0, busy, 2'b00, drv_busy};
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
  parameter int NUM_DRV = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               dp_wr,
  input logic               dp_rd,
  input logic [NUM_DRV-1:0] seek_active,
  input logic [7:0]         status,
  input logic               take_valid,
  input logic               res_pop,
  input logic               proto_err
);
  logic acc_w, acc_r;
  assign acc_w = dp_wr && status[7] && !status[6];
  assign acc_r = dp_rd && status[7] && status[6];

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status[5] == 1'b0 && status[3:2] == 2'b00);

  a_r6_request_gap: assert property (@(posedge clk) disable iff (rst)
    (acc_w || acc_r) |=> !status[7]);

  a_r5_read_dir_busy: assert property (@(posedge clk) disable iff (rst)
    status[6] |-> status[4]);

  a_r8_drive_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status[0] == $past(seek_active[0]));

  a_r9_err_set: assert property (@(posedge clk) disable iff (rst)
    ((dp_wr || dp_rd) && !status[7]) |=> proto_err);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  a_r10_take_strobe: assert property (@(posedge clk) disable iff (rst)
    acc_w |=> take_valid);

  a_r10_pop_strobe: assert property (@(posedge clk) disable iff (rst)
    acc_r |=> res_pop);
endmodule

bind fdc_cmd_handshake hs_checker #(.NUM_DRV(NUM_DRV)) u_chk (
  .clk(clk), .rst(rst), .dp_wr(dp_wr), .dp_rd(dp_rd),
  .seek_active(seek_active), .status(status), .take_valid(take_valid),
  .res_pop(res_pop), .proto_err(proto_err)
);

// File: tb/sim_fdc_cmd_handshake.sv
module sim_fdc_cmd_handshake;
  logic       clk = 0;
  logic       rst = 1;
  logic       dp_wr = 0, dp_rd = 0, exec_done = 0;
  logic [7:0] dp_wdata = 0;
  logic [1:0] seek_active = 0;
  logic [7:0] status, take_data;
  logic [3:0] take_idx, res_idx;
  logic       take_valid, res_pop, exec_phase, proto_err;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #10 clk = ~clk;

  fdc_cmd_handshake u0 (
    .clk(clk), .rst(rst), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata),
    .seek_active(seek_active), .exec_done(exec_done), .status(status),
    .take_valid(take_valid), .take_data(take_data), .take_idx(take_idx),
    .res_pop(res_pop), .res_idx(res_idx), .exec_phase(exec_phase),
    .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void plan(input int c, output int p, output int r, output bit x);
    x = 0;
    case (c)
      3: begin p = 2; r = 0; end
      4: begin p = 1; r = 1; end
      5, 6: begin p = 8; r = 7; x = 1; end
      7: begin p = 1; r = 0; end
      8: begin p = 0; r = 2; end
      15: begin p = 2; r = 0; end
      default: begin p = 0; r = 1; end
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr_byte(input logic [7:0] b, input int idx, input int busy_after);
    @(negedge clk) begin dp_wr = 1; dp_wdata = b; end
    @(negedge clk) dp_wr = 0;
    chk(status[7] == 0, "R6 gap after write", status[7], 0);
    chk(take_valid && take_data == b && take_idx == idx, "R10 take strobe",
        {take_valid, take_idx, take_data}, {1'b1, 4'(idx), b});
    chk(status[4] == busy_after, "R4 busy after write", status[4], busy_after);
  endtask

  task automatic rd_byte(input int idx);
    @(negedge clk) dp_rd = 1;
    @(negedge clk) dp_rd = 0;
    chk(status[7] == 0, "R6 gap after read", status[7], 0);
    chk(res_pop && res_idx == idx, "R10 pop strobe", {res_pop, res_idx}, {1'b1, 4'(idx)});
  endtask

  initial begin
    int p, r;
    bit x;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(status == 8'h80 && !proto_err, "R1 reset state", {proto_err, status}, 9'h080);

    // R3 R4 R5 R7: sweep every table code, upper opcode bits varied
    for (int c = 0; c < 32; c++) begin
      logic [7:0] op;
      op = {3'(c * 5), 5'(c)};
      plan(c, p, r, x);
      chk(status == 8'h80, "R1 idle before opcode", status, 8'h80);
      wr_byte(op, 0, (p > 0 || r > 0 || x) ? 1 : 0);
      chk(status[5] == 0 && status[3:2] == 0, "R2 reserved zero", status, 0);
      for (int i = 0; i < p; i++) begin
        @(negedge clk);
        chk(status == 8'h90, "R3 R5 param request", status, 8'h90);
        wr_byte(8'(i + 8'h30), i + 1, (i + 1 < p || r > 0 || x) ? 1 : 0);
      end
      @(negedge clk);
      if (x) begin
        repeat (3) @(negedge clk);
        chk(status == 8'h10 && exec_phase, "R7 exec holds request low",
            {exec_phase, status}, 9'h110);
        exec_done = 1;
        @(negedge clk) exec_done = 0;
      end
      for (int k = 0; k < r; k++) begin
        chk(status == 8'hD0, "R5 result phase status", status, 8'hD0);
        rd_byte(k);
        @(negedge clk);
      end
      chk(status == 8'h80, "R4 busy cleared at command end", status, 8'h80);
    end
    chk(!proto_err, "R9 no error after clean sweep", proto_err, 0);

    // R8 drive flags
    @(negedge clk) seek_active = 2'b10;
    @(negedge clk);
    chk(status == 8'h82, "R8 drive 1 busy", status, 8'h82);
    seek_active = 2'b01;
    @(negedge clk);
    chk(status[1:0] == 2'b01, "R8 drive 0 busy", status[1:0], 1);
    seek_active = 2'b00;
    @(negedge clk);

    // R9 read in command phase ignored
    @(negedge clk) dp_rd = 1;
    @(negedge clk) dp_rd = 0;
    chk(proto_err && !res_pop && status == 8'h80, "R9 wrong-direction read ignored",
        {proto_err, res_pop, status}, 10'h280);
    repeat (2) @(negedge clk);
    chk(proto_err, "R9 error sticky", proto_err, 1);

    // R1 reset clears error
    rst = 1;
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk(!proto_err && status == 8'h80, "R1 reset clears error", {proto_err, status}, 9'h080);

    // R9 write held into the gap: second beat dropped
    @(negedge clk) begin dp_wr = 1; dp_wdata = 8'h07; end
    @(negedge clk);
    @(negedge clk) dp_wr = 0;
    chk(proto_err && !take_valid, "R9 write during gap ignored",
        {proto_err, take_valid}, 2'b10);
    @(negedge clk);
    chk(status == 8'h90, "R9 still awaiting one parameter", status, 8'h90);
    wr_byte(8'h01, 1, 0);
    @(negedge clk);
    chk(status == 8'h80, "R4 recalibrate ends without result", status, 8'h80);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule